// File: doc/BRIEF.md
# I2C EEPROM slave controller

This block is the serial-bus face of a small byte-wide nonvolatile-style store. It watches an already synchronised I2C clock and data pair and decodes START and STOP conditions. It answers to a device type of 1010 and moves bytes between the bus and a 256-entry internal array. Writes are collected in a 16-byte page buffer and committed when the master ends the transfer with STOP. A self-timed write cycle then starts. While that cycle runs, the slave refuses its own address, so a master can poll for completion.

Reads take three forms. A current-address read uses an internal pointer. A random read is set up by a write header that carries no data. A sequential read streams bytes for as long as the master acknowledges. A write-protect input turns the array read-only and refuses the first data byte. A lock input, driven by a supply supervisor, aborts any transfer in flight and blocks new ones. A write cycle that has already started always runs to completion. The data pin is driven as an open-drain pull-down enable.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After `rst` the slave does not pull SDA (`sda_oe`=0) and `busy_o`=0. START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. No other SDA movement while SCL is high is treated as bus data.
- R2: The slave byte after START is acknowledged only when bits [7:4] equal 1010 and bits [3:1] match `SEL_BITS` in the positions set in `SEL_MASK`. Bit 0 selects read (1) or write (0). The acknowledge is SDA held low during the ninth clock. Any other byte is not acknowledged and the slave stays off the bus until the next START.
- R3: In write mode, the word address byte and each data byte are acknowledged. At STOP the received bytes are stored into the array.
- R4: Within a write, successive data bytes advance only address bits [3:0], so bytes beyond 16 wrap and overwrite earlier bytes of the same page. Bits [7:4] stay fixed.
- R5: A STOP that ends a write with at least one data byte starts a write cycle of `WCYC` clocks, shown on `busy_o`. During that cycle the slave address is not acknowledged, and it is acknowledged again once the cycle ends.
- R6: While `wp_i`=1, the slave and word address bytes are acknowledged, the first data byte is not, and the array is left unchanged.
- R7: The address pointer holds the last accessed address plus one, wrapping from 255 to 0. A current-address read returns the byte at the pointer.
- R8: A write that ends at STOP after the word address and before any data byte loads the pointer and starts no write cycle.
- R9: In read mode, each master acknowledge brings the next byte, with all eight address bits incrementing. A master non-acknowledge makes the slave release SDA and wait for STOP.
- R10: While `lock_i`=1, any transfer is aborted and SDA is released, no byte is acknowledged, and no write cycle starts. A write cycle already running still completes.
- R11: A repeated START after write data discards the buffered bytes, and no write cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, well above the bus rate |
| rst | input | 1 | Synchronous active-high reset |
| lock_i | input | 1 | Access lock from the supply supervisor |
| wp_i | input | 1 | Write protect, 1 makes the array read-only |
| scl_i | input | 1 | Synchronised serial clock |
| sda_i | input | 1 | Synchronised serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| busy_o | output | 1 | Internal write cycle in progress |

## Verification
The assertions take for granted that SCL and SDA are already clean and synchronised to `clk`. They also assume that SDA moves only while SCL is low, except for a deliberate START or STOP, and that each SCL level lasts several clocks. The bench master keeps to this by changing SDA only in the middle of the SCL low phase, with a quarter-period of four clocks between transitions. It raises or drops lock and write protect only while SCL is low. Because the bench drives SDA as a wired-AND with the slave's pull-down, a wrong acknowledge or a wrong read bit shows up at the line level.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADR,
        ST_WADR_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RACK,
        ST_SKIP
    } bus_st_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic dev_match(input logic [7:0] b,
                                       input logic [2:0] sel,
                                       input logic [2:0] msk);
        return (b[7:4] == DEV_TYPE) && (((b[3:1] ^ sel) & msk) == 3'b000);
    endfunction

endpackage

// File: rtl/i2c_ee_edges.sv
module i2c_ee_edges
    import i2c_ee_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        ev.scl_rise = scl_i & ~scl_q;
        ev.scl_fall = ~scl_i & scl_q;
        ev.start    = scl_i & scl_q & sda_q & ~sda_i;
        ev.stop     = scl_i & scl_q & ~sda_q & sda_i;
    end

endmodule

// File: rtl/i2c_ee_wtimer.sv
module i2c_ee_wtimer #(
    parameter int unsigned CYC = 500000
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic busy
);
    localparam int CW = $clog2(CYC + 1);
    logic [CW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst)
            left <= '0;
        else if (go)
            left <= CW'(CYC);
        else if (left != '0)
            left <= left - 1'b1;
    end

    assign busy = (left != '0);

    // R5: the countdown never exceeds the programmed cycle length
    p_left_bound_r5: assert property (@(posedge clk) disable iff (rst)
        left <= CW'(CYC));

    // R5: a new cycle is never launched over a running one
    p_go_free_r5: assert property (@(posedge clk) disable iff (rst)
        go |-> !busy);

endmodule

// File: rtl/i2c_ee_store.sv
module i2c_ee_store #(
    parameter int unsigned AW = 8,
    parameter int unsigned PW = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             push,
    input  logic [PW-1:0]    push_idx,
    input  logic [7:0]       push_data,
    input  logic             commit,
    input  logic [AW-PW-1:0] commit_page,
    input  logic [AW-1:0]    rd_addr,
    output logic [7:0]       rd_data
);
    localparam int DEPTH = 1 << AW;
    localparam int PSZ   = 1 << PW;

    logic [7:0]     mem  [DEPTH];
    logic [7:0]     pbuf [PSZ];
    logic [PSZ-1:0] vmask;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
            vmask <= '0;
        end else begin
            if (commit) begin
                for (int i = 0; i < PSZ; i++)
                    if (vmask[i]) mem[{commit_page, PW'(i)}] <= pbuf[i];
            end
            if (clear || commit) vmask <= '0;
            if (push) vmask[push_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) pbuf[push_idx] <= push_data;
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
    import i2c_ee_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned PAGE_W   = 4,
    parameter int unsigned WCYC     = 500000,
    parameter logic [2:0]  SEL_BITS = 3'b000,
    parameter logic [2:0]  SEL_MASK = 3'b000
) (
    input  logic clk,
    input  logic rst,
    input  logic lock_i,
    input  logic wp_i,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe,
    output logic busy_o
);
    localparam int HI_W = ADDR_W - PAGE_W;

    bus_ev_t           ev;
    bus_st_e           st;
    logic [7:0]        sh, tx, rd_data;
    logic [2:0]        cnt;
    logic              byte_rdy, rw, mack, got_data, oe;
    logic [ADDR_W-1:0] ctr;
    logic [HI_W-1:0]   page;
    logic [PAGE_W-1:0] widx;
    logic              quiet, st_push, st_clear, commit_go;

    i2c_ee_edges u_edges (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_ee_wtimer #(.CYC(WCYC)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .go   (commit_go),
        .busy (busy_o)
    );

    i2c_ee_store #(.AW(ADDR_W), .PW(PAGE_W)) u_store (
        .clk         (clk),
        .rst         (rst),
        .clear       (st_clear),
        .push        (st_push),
        .push_idx    (widx),
        .push_data   (sh),
        .commit      (commit_go),
        .commit_page (page),
        .rd_addr     (ctr),
        .rd_data     (rd_data)
    );

    always_comb begin
        quiet     = !lock_i && !ev.start && !ev.stop;
        st_push   = quiet && (st == ST_WDAT) && ev.scl_fall && byte_rdy && !wp_i;
        commit_go = ev.stop && !lock_i && got_data && (st == ST_WDAT);
        st_clear  = lock_i || ev.start || (ev.stop && !commit_go);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            sh       <= '0;
            tx       <= '0;
            cnt      <= '0;
            byte_rdy <= 1'b0;
            rw       <= 1'b0;
            mack     <= 1'b0;
            got_data <= 1'b0;
            oe       <= 1'b0;
            ctr      <= '0;
            page     <= '0;
            widx     <= '0;
        end else if (lock_i) begin
            st       <= ST_IDLE;
            oe       <= 1'b0;
            byte_rdy <= 1'b0;
            got_data <= 1'b0;
        end else if (ev.start) begin
            st       <= ST_DEV;
            cnt      <= '0;
            oe       <= 1'b0;
            byte_rdy <= 1'b0;
            got_data <= 1'b0;
        end else if (ev.stop) begin
            st       <= ST_IDLE;
            oe       <= 1'b0;
            byte_rdy <= 1'b0;
            got_data <= 1'b0;
        end else begin
            unique case (st)
                ST_DEV, ST_WADR, ST_WDAT: begin
                    if (ev.scl_rise) begin
                        sh  <= {sh[6:0], sda_i};
                        cnt <= cnt + 3'd1;
                        if (cnt == 3'd7) byte_rdy <= 1'b1;
                    end else if (ev.scl_fall && byte_rdy) begin
                        byte_rdy <= 1'b0;
                        cnt      <= '0;
                        if (st == ST_DEV) begin
                            if (dev_match(sh, SEL_BITS, SEL_MASK) && !busy_o) begin
                                oe <= 1'b1;
                                rw <= sh[0];
                                st <= ST_DEV_ACK;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end else if (st == ST_WADR) begin
                            oe   <= 1'b1;
                            ctr  <= sh[ADDR_W-1:0];
                            page <= sh[ADDR_W-1:PAGE_W];
                            widx <= sh[PAGE_W-1:0];
                            st   <= ST_WADR_ACK;
                        end else if (wp_i) begin
                            st <= ST_SKIP;
                        end else begin
                            oe       <= 1'b1;
                            got_data <= 1'b1;
                            widx     <= widx + PAGE_W'(1);
                            ctr      <= {page, widx + PAGE_W'(1)};
                            st       <= ST_WDAT_ACK;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (ev.scl_fall) begin
                        cnt <= '0;
                        if (rw) begin
                            tx  <= rd_data;
                            oe  <= ~rd_data[7];
                            ctr <= ctr + 1'b1;
                            st  <= ST_RDAT;
                        end else begin
                            oe <= 1'b0;
                            st <= ST_WADR;
                        end
                    end
                end
                ST_WADR_ACK, ST_WDAT_ACK: begin
                    if (ev.scl_fall) begin
                        oe  <= 1'b0;
                        cnt <= '0;
                        st  <= ST_WDAT;
                    end
                end
                ST_RDAT: begin
                    if (ev.scl_fall) begin
                        if (cnt == 3'd7) begin
                            oe <= 1'b0;
                            st <= ST_RACK;
                        end else begin
                            tx  <= {tx[6:0], 1'b0};
                            oe  <= ~tx[6];
                            cnt <= cnt + 3'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (ev.scl_rise) begin
                        mack <= ~sda_i;
                    end else if (ev.scl_fall) begin
                        cnt <= '0;
                        if (mack) begin
                            tx  <= rd_data;
                            oe  <= ~rd_data[7];
                            ctr <= ctr + 1'b1;
                            st  <= ST_RDAT;
                        end else begin
                            st <= ST_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_oe = oe;

    // R10: the lock releases the bus on the next clock
    p_lock_release_r10: assert property (@(posedge clk) disable iff (rst)
        lock_i |=> !sda_oe);

    // R10: no write cycle is launched while locked
    p_lock_no_commit_r10: assert property (@(posedge clk) disable iff (rst)
        commit_go |-> !lock_i);

    // R5: the address byte that completes during a write cycle is refused
    p_busy_nack_r5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DEV && byte_rdy && ev.scl_fall && busy_o && quiet)
        |=> (st == ST_IDLE && !sda_oe));

    // R6: a protected data byte is never acknowledged
    p_wp_nack_r6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WDAT && byte_rdy && ev.scl_fall && wp_i && quiet)
        |=> !sda_oe);

endmodule

// File: tb/i2c_eeprom_slave_test.sv
module i2c_eeprom_slave_test;
    localparam int WCYC = 1500;
    localparam int Q    = 4;
    localparam logic [7:0] DW = 8'hA0;
    localparam logic [7:0] DR = 8'hA1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lock = 1'b0;
    logic wp = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe, busy;
    wire  line = sda_m & ~sda_oe;

    int total = 0;
    int bad = 0;
    int oe_err = 0;
    int cyc = 0;
    int t_stop = 0;
    bit done = 1'b0;
    logic [7:0] mm [256];
    logic [7:0] ctr_m = 8'h00;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    i2c_eeprom_slave #(.WCYC(WCYC)) uut (
        .clk    (clk),
        .rst    (rst),
        .lock_i (lock),
        .wp_i   (wp),
        .scl_i  (scl),
        .sda_i  (line),
        .sda_oe (sda_oe),
        .busy_o (busy)
    );

    task automatic finish_all();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one bus bit; checks the slave pull-down on every clock of the high phase
    task automatic sbit(input logic mb, input logic exo, output logic got);
        sda_m = mb;
        tick(Q);
        scl = 1'b1;
        got = 1'b1;
        for (int i = 0; i < 2 * Q; i++) begin
            if (i == Q) got = line;
            if (sda_oe !== exo) oe_err++;
            tick(1);
        end
        scl = 1'b0;
        tick(Q);
    endtask

    task automatic start_c();
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b0; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic stop_c();
        sda_m = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b1; t_stop = cyc;
        tick(Q);
    endtask

    task automatic send(input logic [7:0] b, input logic eack, input string tag);
        logic g;
        oe_err = 0;
        for (int i = 7; i >= 0; i--) sbit(b[i], 1'b0, g);
        sbit(1'b1, eack, g);
        chk(oe_err == 0 && g == ~eack, tag, {oe_err[7:0], 3'b0, g}, {8'h00, 3'b0, ~eack});
    endtask

    task automatic recv(input logic [7:0] e, input logic mack, input string tag);
        logic g;
        logic [7:0] got;
        oe_err = 0;
        for (int i = 7; i >= 0; i--) begin
            sbit(1'b1, ~e[i], g);
            got[i] = g;
        end
        sbit(~mack, 1'b0, g);
        chk(oe_err == 0 && got == e, tag, {oe_err[7:0], got}, {8'h00, e});
    endtask

    task automatic wait_cycle(input string tag);
        int el;
        chk(busy == 1'b1, {tag, " busy after STOP"}, busy, 1);
        while (busy) tick(1);
        el = cyc - t_stop;
        chk(el >= WCYC && el <= WCYC + 3, {tag, " cycle length"}, el, WCYC);
    endtask

    task automatic wr(input logic [7:0] a, input int n, input logic [7:0] seed,
                      input bit hold, input string tag);
        logic [3:0] idx;
        start_c();
        send(DW, 1'b1, {tag, " dev"});
        send(a, 1'b1, {tag, " word addr"});
        for (int k = 0; k < n; k++) send(8'(seed + k * 13), 1'b1, {tag, " data"});
        stop_c();
        if (hold) lock = 1'b1;
        for (int k = 0; k < n; k++) begin
            idx = 4'(a[3:0] + k);
            mm[{a[7:4], idx}] = 8'(seed + k * 13);
        end
        ctr_m = {a[7:4], 4'(a[3:0] + n)};
        wait_cycle(tag);
        lock = 1'b0;
    endtask

    task automatic rd_rand(input logic [7:0] a, input int n, input string tag);
        logic g;
        start_c();
        send(DW, 1'b1, {tag, " dummy dev"});
        send(a, 1'b1, {tag, " dummy addr"});
        start_c();
        send(DR, 1'b1, {tag, " read dev"});
        for (int k = 0; k < n; k++)
            recv(mm[8'(a + k)], (k < n - 1), {tag, " read data"});
        oe_err = 0;
        sbit(1'b1, 1'b0, g);
        chk(oe_err == 0, "R9 released after master NACK", oe_err, 0);
        stop_c();
        ctr_m = 8'(a + n);
    endtask

    task automatic rd_cur(input int n, input string tag);
        start_c();
        send(DR, 1'b1, {tag, " dev"});
        for (int k = 0; k < n; k++)
            recv(mm[8'(ctr_m + k)], (k < n - 1), {tag, " data"});
        stop_c();
        ctr_m = 8'(ctr_m + n);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired act=%0d exp=0", cyc);
        finish_all();
    end

    initial begin
        for (int i = 0; i < 256; i++) mm[i] = 8'h00;
        tick(4);
        rst = 1'b0;
        tick(2);
        // R1: quiet after reset
        chk(sda_oe == 1'b0, "R1 no drive after reset", sda_oe, 0);
        chk(busy == 1'b0, "R1 not busy after reset", busy, 0);

        // R3, R5: byte write, commit, timed cycle
        wr(8'h10, 1, 8'h5A, 1'b0, "R3 byte write");
        rd_rand(8'h10, 1, "R3 readback");
        // R7: pointer is last address + 1
        rd_cur(1, "R7 current read");

        // R8: header-only write loads pointer, no cycle
        start_c();
        send(DW, 1'b1, "R8 dev");
        send(8'h10, 1'b1, "R8 addr");
        stop_c();
        tick(2);
        chk(busy == 1'b0, "R8 no write cycle", busy, 0);
        ctr_m = 8'h10;
        rd_cur(1, "R8 pointer loaded");

        // R4 + R9: page wrap then sequential read of the page
        wr(8'h2C, 20, 8'h10, 1'b0, "R4 page write");
        rd_rand(8'h20, 16, "R9 sequential page");

        // R5: acknowledge polling
        start_c();
        send(DW, 1'b1, "R5 dev");
        send(8'h70, 1'b1, "R5 addr");
        send(8'h3C, 1'b1, "R5 data");
        stop_c();
        mm[8'h70] = 8'h3C;
        start_c();
        send(DW, 1'b0, "R5 poll refused while busy");
        stop_c();
        while (busy) tick(1);
        start_c();
        send(DW, 1'b1, "R5 poll accepted when idle");
        stop_c();
        rd_rand(8'h70, 1, "R5 readback");

        // R6: write protect
        wp = 1'b1;
        start_c();
        send(DW, 1'b1, "R6 dev");
        send(8'h40, 1'b1, "R6 addr");
        send(8'hEE, 1'b0, "R6 first data refused");
        send(8'h11, 1'b0, "R6 later data refused");
        stop_c();
        tick(2);
        chk(busy == 1'b0, "R6 no write cycle", busy, 0);
        wp = 1'b0;
        rd_rand(8'h40, 1, "R6 array unchanged");

        // R2: address decode
        start_c();
        send(8'hAE, 1'b1, "R2 don't-care select bits");
        stop_c();
        start_c();
        send(8'hB0, 1'b0, "R2 wrong type refused");
        stop_c();
        start_c();
        send(8'h20, 1'b0, "R2 other type refused");
        stop_c();

        // R7, R9: wrap of the pointer and of sequential reads
        wr(8'h00, 1, 8'h33, 1'b0, "R7 seed low");
        wr(8'hFF, 1, 8'hC4, 1'b0, "R7 seed high");
        rd_rand(8'hFF, 1, "R7 read top");
        rd_cur(1, "R7 wrap to zero");
        rd_rand(8'hFE, 4, "R9 sequential wrap");

        // R10: lock mid transfer
        start_c();
        send(DW, 1'b1, "R10 dev before lock");
        lock = 1'b1;
        send(8'h60, 1'b0, "R10 addr ignored");
        send(8'h99, 1'b0, "R10 data ignored");
        stop_c();
        lock = 1'b0;
        tick(2);
        chk(busy == 1'b0, "R10 no cycle after abort", busy, 0);
        rd_rand(8'h60, 1, "R10 array unchanged");

        // R10: lock at STOP blocks the write
        start_c();
        send(DW, 1'b1, "R10 dev");
        send(8'h61, 1'b1, "R10 addr");
        send(8'h42, 1'b1, "R10 data");
        lock = 1'b1;
        stop_c();
        tick(2);
        chk(busy == 1'b0, "R10 locked STOP starts nothing", busy, 0);
        lock = 1'b0;
        rd_rand(8'h61, 1, "R10 locked write discarded");

        // R10: running cycle survives the lock
        wr(8'h62, 2, 8'h81, 1'b1, "R10 cycle under lock");
        rd_rand(8'h62, 2, "R10 locked cycle data");

        // R11: repeated START discards buffered data
        start_c();
        send(DW, 1'b1, "R11 dev");
        send(8'h50, 1'b1, "R11 addr");
        send(8'h77, 1'b1, "R11 data");
        start_c();
        stop_c();
        tick(2);
        chk(busy == 1'b0, "R11 no write cycle", busy, 0);
        rd_rand(8'h50, 1, "R11 array unchanged");

        finish_all();
    end

endmodule